// File: doc/BRIEF.md
# Priority Interrupt Level Controller

This block holds a group of sixteen interrupt levels, each with its own four-state machine and an enable flag, and picks which level is offered to the processor next. A level moves through these states: DISARMED (triggers are dropped), ARMED (ready to accept a trigger), WAITING (triggered, asking for service) and ACTIVE (being serviced). The named transitions are: *arm* (any state to ARMED), *disarm* (any state to DISARMED), *trigger* (ARMED to WAITING), *grant* (WAITING to ACTIVE on acknowledge), *grant-rearm* (WAITING straight back to ARMED, for levels whose service is a short counter update), *clear-to-armed* and *clear-to-disarmed* (ACTIVE to ARMED or DISARMED), and *replay* (a level that leaves ACTIVE or WAITING toward ARMED while a trigger is held goes to WAITING instead).

The lowest-numbered level has the highest priority. The lowest-numbered waiting, enabled level is offered only when it outranks every active level, the group is not inhibited, and no higher-priority group upstream blocks it. An inhibited group withdraws its waiting levels from the priority chain, so that groups further down can be served. A control port applies arm, disarm, enable, disable and trigger commands to every level selected by a mask, and a clear command returns the highest-priority active level to ARMED or DISARMED.

Top module: `pic_group`

## Requirements
- R1: After reset every level is DISARMED and disabled, and `irq_req_o` and `chain_out_o` are 0.
- R2: `cmd_op_i` codes are 0 none, 1 disarm, 2 arm, 3 enable, 4 disable, 5 trigger and 6 clear-highest-active. Bit i of `cmd_mask_i` selects level i, where level 0 has the highest priority. Arm and disarm take effect from any state and discard a held trigger. Enable and disable change only the enable flag.
- R3: A disabled level still moves from ARMED to WAITING on a trigger, but it never becomes ACTIVE. Once it is enabled it can be granted.
- R4: A trigger, from `trig_i` or from the trigger command, is ignored by a DISARMED level and moves an ARMED level to WAITING one cycle later.
- R5: A trigger that reaches a WAITING or ACTIVE level is held, including one that arrives in the same cycle as that level's grant. When the level later returns toward ARMED, it enters WAITING instead.
- R6: `irq_level_o` is the lowest-numbered waiting, enabled level. `irq_req_o` is 1 only if that number is lower than that of every ACTIVE level.
- R7: When `ack_i` is 1 while `irq_req_o` is 1, the offered level is ACTIVE one cycle later. No level becomes ACTIVE in any other way.
- R8: If `ack_rearm_i` is 1 together with such an acknowledge, the offered level goes to ARMED (or to WAITING if a trigger is held) and does not become ACTIVE.
- R9: Command 6 moves the lowest-numbered ACTIVE level to ARMED if `cmd_rearm_i` is 1 and to DISARMED otherwise. All other ACTIVE levels stay ACTIVE.
- R10: While `inhibit_i` is 1, `irq_req_o` is 0, an acknowledge has no effect, and waiting levels do not drive `chain_out_o`.
- R11: While `chain_in_i` is 1, `irq_req_o` is 0 and an acknowledge has no effect.
- R12: `chain_out_o` is 1 when any level is ACTIVE, or when the group is not inhibited and a level is WAITING and enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 16 | Trigger pulse per level |
| cmd_op_i | input | 3 | Control command code |
| cmd_mask_i | input | 16 | Level selection mask for the command |
| cmd_rearm_i | input | 1 | For the clear command: 1 returns the level to ARMED, 0 to DISARMED |
| ack_i | input | 1 | Processor is at an interruptible point and takes the offered level |
| ack_rearm_i | input | 1 | The acknowledged level completes at once and is re-armed |
| inhibit_i | input | 1 | Group inhibit |
| chain_in_i | input | 1 | A higher-priority group is blocking this one |
| irq_req_o | output | 1 | A level is offered |
| irq_level_o | output | 4 | Number of the offered level |
| chain_out_o | output | 1 | This group blocks lower-priority groups |
| armed_o | output | 16 | Levels in ARMED |
| waiting_o | output | 16 | Levels in WAITING |
| active_o | output | 16 | Levels in ACTIVE |
| enabled_o | output | 16 | Enable flags |

## Verification
A grant and a new trigger can land on the same level in the same cycle. The bench drives `ack_i` and that level's `trig_i` bit in one cycle, then checks that the level is ACTIVE with nothing left waiting. After a clear-to-armed it checks that the level is WAITING and offered again, which shows the trigger was held and not lost. Clear and trigger also meet: clearing a level that holds a trigger must replay it into WAITING and not drop it to ARMED.

// File: rtl/pic_pkg.sv
package pic_pkg;

    typedef enum logic [1:0] {
        LV_DISARMED = 2'd0,
        LV_ARMED    = 2'd1,
        LV_WAITING  = 2'd2,
        LV_ACTIVE   = 2'd3
    } lvl_state_t;

    typedef enum logic [2:0] {
        CMD_NONE    = 3'd0,
        CMD_DISARM  = 3'd1,
        CMD_ARM     = 3'd2,
        CMD_ENABLE  = 3'd3,
        CMD_DISABLE = 3'd4,
        CMD_TRIGGER = 3'd5,
        CMD_CLEAR   = 3'd6
    } pic_cmd_t;

endpackage

// File: rtl/pic_level_cell.sv
module pic_level_cell
    import pic_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm_i,
    input  logic       disarm_i,
    input  logic       en_set_i,
    input  logic       en_clr_i,
    input  logic       trig_i,
    input  logic       grant_i,
    input  logic       grant_rearm_i,
    input  logic       clear_i,
    input  logic       clear_to_armed_i,
    output lvl_state_t state_o,
    output logic       enabled_o
);

    lvl_state_t state_q, state_d;
    logic       held_q, held_d;
    logic       en_q, en_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LV_DISARMED;
            held_q  <= 1'b0;
            en_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            held_q  <= held_d;
            en_q    <= en_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        held_d  = held_q;
        en_d    = en_q;

        // grant / grant-rearm
        if (grant_i) begin
            if (grant_rearm_i) begin
                state_d = held_q ? LV_WAITING : LV_ARMED;
                held_d  = 1'b0;
            end else begin
                state_d = LV_ACTIVE;
            end
        end

        // clear-to-armed / clear-to-disarmed
        if (clear_i) begin
            if (clear_to_armed_i) begin
                state_d = held_q ? LV_WAITING : LV_ARMED;
            end else begin
                state_d = LV_DISARMED;
            end
            held_d = 1'b0;
        end

        // arm / disarm from any state
        if (disarm_i) begin
            state_d = LV_DISARMED;
            held_d  = 1'b0;
        end else if (arm_i) begin
            state_d = LV_ARMED;
            held_d  = 1'b0;
        end

        // trigger applies to the state reached above
        if (trig_i) begin
            unique case (state_d)
                LV_DISARMED: ;
                LV_ARMED:    state_d = LV_WAITING;
                LV_WAITING,
                LV_ACTIVE:   held_d = 1'b1;
            endcase
        end

        if (en_set_i) begin
            en_d = 1'b1;
        end else if (en_clr_i) begin
            en_d = 1'b0;
        end
    end

    // outputs
    always_comb begin
        state_o   = state_q;
        enabled_o = en_q;
    end

    // R3: a disabled waiting level is never promoted
    p_disabled_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LV_WAITING && !en_q) |=> (state_q != LV_ACTIVE));

    // R4: a trigger on a disarmed level is dropped
    p_disarmed_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LV_DISARMED && trig_i && !arm_i) |=> (state_q != LV_WAITING));

    // R9: an active level stays active unless cleared or re-commanded
    p_active_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LV_ACTIVE && !clear_i && !arm_i && !disarm_i) |=> (state_q == LV_ACTIVE));

endmodule

// File: rtl/pic_prio_pick.sv
module pic_prio_pick #(
    parameter int NUM_LEVELS = 16,
    localparam int LVL_W = $clog2(NUM_LEVELS)
) (
    input  logic [NUM_LEVELS-1:0] cand_i,
    input  logic [NUM_LEVELS-1:0] active_i,
    output logic                  win_o,
    output logic [LVL_W-1:0]      win_idx_o
);

    logic             cand_any, act_any;
    logic [LVL_W-1:0] cand_idx, act_idx;

    // scan downward so that the lowest number is the last one written
    always_comb begin
        cand_any = 1'b0;
        cand_idx = '0;
        act_any  = 1'b0;
        act_idx  = '0;
        for (int i = NUM_LEVELS - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                cand_any = 1'b1;
                cand_idx = LVL_W'(i);
            end
            if (active_i[i]) begin
                act_any = 1'b1;
                act_idx = LVL_W'(i);
            end
        end
    end

    always_comb begin
        win_idx_o = cand_idx;
        win_o     = cand_any && (!act_any || (cand_idx < act_idx));
    end

endmodule

// File: rtl/pic_clear_pick.sv
module pic_clear_pick #(
    parameter int NUM_LEVELS = 16
) (
    input  logic [NUM_LEVELS-1:0] active_i,
    output logic [NUM_LEVELS-1:0] first_o
);

    // isolate the lowest set bit
    always_comb begin
        first_o = active_i & (~active_i + NUM_LEVELS'(1));
    end

endmodule

// File: rtl/pic_group.sv
module pic_group
    import pic_pkg::*;
#(
    parameter int NUM_LEVELS = 16,
    localparam int LVL_W = $clog2(NUM_LEVELS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LEVELS-1:0] trig_i,
    input  logic [2:0]            cmd_op_i,
    input  logic [NUM_LEVELS-1:0] cmd_mask_i,
    input  logic                  cmd_rearm_i,
    input  logic                  ack_i,
    input  logic                  ack_rearm_i,
    input  logic                  inhibit_i,
    input  logic                  chain_in_i,
    output logic                  irq_req_o,
    output logic [LVL_W-1:0]      irq_level_o,
    output logic                  chain_out_o,
    output logic [NUM_LEVELS-1:0] armed_o,
    output logic [NUM_LEVELS-1:0] waiting_o,
    output logic [NUM_LEVELS-1:0] active_o,
    output logic [NUM_LEVELS-1:0] enabled_o
);

    pic_cmd_t              op;
    lvl_state_t            st [NUM_LEVELS];
    logic [NUM_LEVELS-1:0] eligible;
    logic [NUM_LEVELS-1:0] clear_sel;
    logic                  win;
    logic [LVL_W-1:0]      win_idx;
    logic                  take;

    assign op = pic_cmd_t'(cmd_op_i);

    for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_lvl
        logic sel;
        assign sel = cmd_mask_i[i];

        pic_level_cell u_cell (
            .clk              (clk),
            .rst_n            (rst_n),
            .arm_i            (sel && op == CMD_ARM),
            .disarm_i         (sel && op == CMD_DISARM),
            .en_set_i         (sel && op == CMD_ENABLE),
            .en_clr_i         (sel && op == CMD_DISABLE),
            .trig_i           (trig_i[i] || (sel && op == CMD_TRIGGER)),
            .grant_i          (take && win_idx == LVL_W'(i)),
            .grant_rearm_i    (ack_rearm_i),
            .clear_i          (op == CMD_CLEAR && clear_sel[i]),
            .clear_to_armed_i (cmd_rearm_i),
            .state_o          (st[i]),
            .enabled_o        (enabled_o[i])
        );

        assign armed_o[i]   = (st[i] == LV_ARMED);
        assign waiting_o[i] = (st[i] == LV_WAITING);
        assign active_o[i]  = (st[i] == LV_ACTIVE);
        assign eligible[i]  = waiting_o[i] && enabled_o[i];
    end

    pic_prio_pick #(.NUM_LEVELS(NUM_LEVELS)) u_pick (
        .cand_i    (eligible),
        .active_i  (active_o),
        .win_o     (win),
        .win_idx_o (win_idx)
    );

    pic_clear_pick #(.NUM_LEVELS(NUM_LEVELS)) u_clear (
        .active_i (active_o),
        .first_o  (clear_sel)
    );

    always_comb begin
        irq_req_o   = win && !inhibit_i && !chain_in_i;
        irq_level_o = win_idx;
        take        = ack_i && irq_req_o;
        chain_out_o = (|active_o) || (!inhibit_i && (|eligible));
    end

    // R7: no level turns active without an acknowledge
    p_only_ack_activates_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |=> ((active_o & ~$past(active_o)) == '0));

    // R10: an acknowledge under inhibit adds no active level
    p_inhibit_blocks_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && inhibit_i) |=> ($countones(active_o) <= $countones($past(active_o))));

    // R6: the offered level outranks every active level
    p_offer_outranks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> ((active_o & ((NUM_LEVELS'(2) << irq_level_o) - NUM_LEVELS'(1))) == '0));

    // R7: at most one level becomes active per cycle
    p_single_activation_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> $onehot0(active_o & ~$past(active_o)));

endmodule

// File: tb/test_pic_group.sv
module test_pic_group;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] trig_i;
    logic [2:0]  cmd_op_i;
    logic [15:0] cmd_mask_i;
    logic        cmd_rearm_i;
    logic        ack_i;
    logic        ack_rearm_i;
    logic        inhibit_i;
    logic        chain_in_i;
    logic        irq_req_o;
    logic [3:0]  irq_level_o;
    logic        chain_out_o;
    logic [15:0] armed_o, waiting_o, active_o, enabled_o;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    pic_group i_pic_group (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .cmd_op_i(cmd_op_i),
        .cmd_mask_i(cmd_mask_i), .cmd_rearm_i(cmd_rearm_i), .ack_i(ack_i),
        .ack_rearm_i(ack_rearm_i), .inhibit_i(inhibit_i), .chain_in_i(chain_in_i),
        .irq_req_o(irq_req_o), .irq_level_o(irq_level_o), .chain_out_o(chain_out_o),
        .armed_o(armed_o), .waiting_o(waiting_o), .active_o(active_o), .enabled_o(enabled_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; trig_i = '0; cmd_op_i = '0; cmd_mask_i = '0; cmd_rearm_i = 1'b0;
        ack_i = 1'b0; ack_rearm_i = 1'b0; inhibit_i = 1'b0; chain_in_i = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic cmd(input logic [2:0] op, input logic [15:0] m, input logic rearm);
        cmd_op_i = op; cmd_mask_i = m; cmd_rearm_i = rearm;
        step();
        cmd_op_i = '0; cmd_mask_i = '0; cmd_rearm_i = 1'b0;
    endtask

    task automatic pulse_trig(input logic [15:0] m);
        trig_i = m;
        step();
        trig_i = '0;
    endtask

    task automatic pulse_ack(input logic rearm);
        ack_i = 1'b1; ack_rearm_i = rearm;
        step();
        ack_i = 1'b0; ack_rearm_i = 1'b0;
    endtask

    task automatic arm_en(input logic [15:0] m);
        cmd(3'd2, m, 1'b0);
        cmd(3'd3, m, 1'b0);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 armed", armed_o, 0);
        check("R1 waiting", waiting_o, 0);
        check("R1 active", active_o, 0);
        check("R1 enabled", enabled_o, 0);
        check("R1 req", irq_req_o, 0);
        check("R1 chain_out", chain_out_o, 0);
    endtask

    task automatic t_trigger_basic();
        do_reset();
        cmd(3'd2, 16'h00F0, 1'b0);
        check("R2 arm mask", armed_o, 32'h00F0);
        pulse_trig(16'h0011);
        check("R4 waiting", waiting_o, 32'h0010);
        check("R4 armed left", armed_o, 32'h00E0);
    endtask

    task automatic t_disabled();
        do_reset();
        cmd(3'd2, 16'h0008, 1'b0);
        pulse_trig(16'h0008);
        check("R3 disabled waits", waiting_o, 32'h0008);
        check("R3 no req", irq_req_o, 0);
        pulse_ack(1'b0);
        check("R3 no activation", active_o, 0);
        cmd(3'd3, 16'h0008, 1'b0);
        check("R3 req after enable", irq_req_o, 1);
        check("R3 level", irq_level_o, 3);
        pulse_ack(1'b0);
        check("R3 granted", active_o, 32'h0008);
    endtask

    task automatic t_priority();
        do_reset();
        arm_en(16'hFFFF);
        pulse_trig(16'h0A00);
        check("R6 req", irq_req_o, 1);
        check("R6 lowest number", irq_level_o, 9);
        pulse_ack(1'b0);
        check("R7 active", active_o, 32'h0200);
        check("R7 waiting", waiting_o, 32'h0800);
        check("R6 blocked by active", irq_req_o, 0);
        pulse_trig(16'h0004);
        check("R6 preempt req", irq_req_o, 1);
        check("R6 preempt level", irq_level_o, 2);
        pulse_ack(1'b0);
        check("R7 nested active", active_o, 32'h0204);
        cmd(3'd6, 16'h0000, 1'b1);
        check("R9 clear first", active_o, 32'h0200);
        check("R9 to armed", armed_o[2], 1);
        cmd(3'd6, 16'h0000, 1'b0);
        check("R9 clear second", active_o, 0);
        check("R9 to disarmed", armed_o[9], 0);
        check("R6 next offered", irq_level_o, 11);
        check("R6 next req", irq_req_o, 1);
    endtask

    task automatic t_pending();
        do_reset();
        arm_en(16'h0020);
        pulse_trig(16'h0020);
        ack_i = 1'b1; trig_i = 16'h0020;
        step();
        ack_i = 1'b0; trig_i = '0;
        check("R5 same-cycle active", active_o, 32'h0020);
        check("R5 same-cycle waiting", waiting_o, 0);
        cmd(3'd6, 16'h0000, 1'b1);
        check("R5 replayed", waiting_o, 32'h0020);
        check("R5 offered again", irq_level_o, 5);
        check("R5 req again", irq_req_o, 1);
    endtask

    task automatic t_rearm();
        do_reset();
        arm_en(16'h0080);
        pulse_trig(16'h0080);
        pulse_trig(16'h0080);
        pulse_ack(1'b1);
        check("R8 held replays", waiting_o, 32'h0080);
        check("R8 not active", active_o, 0);
        pulse_ack(1'b1);
        check("R8 rearmed", armed_o, 32'h0080);
        check("R8 still not active", active_o, 0);
    endtask

    task automatic t_inhibit();
        do_reset();
        arm_en(16'h0002);
        pulse_trig(16'h0002);
        check("R12 chain from waiting", chain_out_o, 1);
        inhibit_i = 1'b1;
        step();
        check("R10 req", irq_req_o, 0);
        check("R10 chain", chain_out_o, 0);
        pulse_ack(1'b0);
        check("R10 ack ignored", active_o, 0);
        check("R10 still waiting", waiting_o, 32'h0002);
        inhibit_i = 1'b0;
        pulse_ack(1'b0);
        check("R7 active after release", active_o, 32'h0002);
        inhibit_i = 1'b1;
        step();
        check("R12 chain from active", chain_out_o, 1);
        inhibit_i = 1'b0;
    endtask

    task automatic t_chain_in();
        do_reset();
        arm_en(16'h0100);
        pulse_trig(16'h0100);
        chain_in_i = 1'b1;
        step();
        check("R11 req blocked", irq_req_o, 0);
        pulse_ack(1'b0);
        check("R11 ack ignored", active_o, 0);
        chain_in_i = 1'b0;
        step();
        check("R11 req back", irq_req_o, 1);
        check("R11 level", irq_level_o, 8);
    endtask

    task automatic t_cmds();
        do_reset();
        arm_en(16'h0030);
        pulse_trig(16'h0030);
        cmd(3'd4, 16'h0010, 1'b0);
        check("R2 disable flag", enabled_o, 32'h0020);
        check("R2 disable keeps state", waiting_o, 32'h0030);
        check("R2 offered", irq_level_o, 5);
        cmd(3'd1, 16'h0020, 1'b0);
        check("R2 disarm waiting", waiting_o, 32'h0010);
        check("R2 no req", irq_req_o, 0);
        cmd(3'd5, 16'h0001, 1'b0);
        check("R4 cmd trigger disarmed", waiting_o, 32'h0010);
        cmd(3'd2, 16'h0010, 1'b0);
        check("R2 arm from waiting", armed_o, 32'h0010);
        cmd(3'd5, 16'h0010, 1'b0);
        check("R4 cmd trigger armed", waiting_o, 32'h0010);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_trigger_basic();
        t_disabled();
        t_priority();
        t_pending();
        t_rearm();
        t_inhibit();
        t_chain_in();
        t_cmds();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule